// File: doc/BRIEF.md
# Byte-Memory Boot Loader Controller

This block loads a program into on-chip program memory after reset, and it keeps the instruction core stalled until that load is finished. On the cycle that reset goes away, it latches three mode pins and picks a boot path from them. In byte-stream boot, the block reads a fixed number of program words from an external byte-wide memory. It builds each 24-bit word from three bytes, most significant byte first, and writes the words into program memory starting at location 0. In host boot, an external agent writes as many program words as it needs through a simple write port. The core is released when that agent writes location 0.

When either path completes, the block gives a single-cycle completion pulse and raises the core run enable in the same cycle. The core then starts fetching from address 0. Any other mode value leaves the core stalled and the external memory idle. A registered core read port gives access to program memory. Reset does not clear program memory.

Top module: `boot_loader`

## Requirements
- R1: The mode pins are `{C,B,A}`, latched on the last clock edge with `rstN` low. The value 3'b000 selects byte-stream boot and 3'b101 selects host boot. Every other value keeps `coreRun` low and `byteRd` low until the next reset.
- R2: In byte-stream boot, the first byte read uses byte address 0. Each later read uses the previous address plus one. The address stays constant while `byteRd` is high.
- R3: Each byte read holds `byteRd` high for exactly WAIT_CYCLES consecutive cycles, then low for exactly one cycle before the next read. The byte is taken on the last high cycle.
- R4: A byte-stream boot performs exactly 3*BOOT_WORDS reads (96 by default) and then no more.
- R5: After byte-stream boot, program word k (k < BOOT_WORDS) holds byte 3k in bits 23:16, byte 3k+1 in bits 15:8 and byte 3k+2 in bits 7:0. Words at and above BOOT_WORDS are untouched.
- R6: `coreRun` is low from reset until completion. `bootDone` is high for exactly one cycle, and `coreRun` rises in that same cycle and stays high until the next reset. In byte-stream boot, `bootDone` is seen 1 + 3*BOOT_WORDS*(WAIT_CYCLES+1) cycles after reset release.
- R7: In host boot, writes to any address are stored while the core stays held and no byte reads occur. A write to address 0 is stored, and the cycle after it shows `bootDone` and `coreRun` high.
- R8: Host writes are ignored during byte-stream boot and in the mode values that select neither boot path.
- R9: The word at `coreRdAddr` appears on `coreRdData` one clock edge later.
- R10: Reset does not alter program memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; mode pins latched while low |
| modePins | input | 3 | Boot mode select {C,B,A} |
| byteAddr | output | EXT_AW | External byte memory address |
| byteRd | output | 1 | External byte read strobe, active high |
| byteData | input | 8 | Byte returned by external memory |
| hostWr | input | 1 | Host program write enable |
| hostAddr | input | PM_AW | Host program write address |
| hostData | input | PM_WIDTH | Host program write data |
| coreRdAddr | input | PM_AW | Core program read address |
| coreRdData | output | PM_WIDTH | Core program read data, one cycle latency |
| coreRun | output | 1 | Core execution enable (execution starts at address 0) |
| bootDone | output | 1 | Single-cycle boot completion pulse |

## Verification
The bench drives every input on the falling edge and samples every result on the falling edge, so each result is read half a period after the rising edge that produced it. A read strobe shows up one edge after reset release. Each byte takes WAIT_CYCLES+1 edges, and the completion pulse lands exactly 1 + 96*(WAIT_CYCLES+1) falling edges after release, which is counted and compared. A host write to address 0 shows its pulse at the very next falling edge, and core read data is checked one falling edge after its address is applied.

// File: rtl/boot_pkg.sv
package boot_pkg;

  localparam logic [2:0] MODE_BYTE_BOOT = 3'b000;
  localparam logic [2:0] MODE_HOST_BOOT = 3'b101;

  typedef enum logic [2:0] {
    S_START,
    S_READ,
    S_GAP,
    S_FINISH,
    S_RUN,
    S_HOST,
    S_HALT
  } bootState_t;

  typedef struct packed {
    logic readStrobe;
    logic capture;
    logic stepByte;
    logic hostAccept;
  } bootCtl_t;

endpackage

// File: rtl/boot_control.sv
module boot_control
  import boot_pkg::*;
#(
  parameter int WAIT_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modePins,
  input  logic       wordEnd,
  input  logic       lastWord,
  input  logic       hostZeroWr,
  output bootCtl_t   ctl,
  output logic       coreRun,
  output logic       bootDone
);

  localparam int WCW = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES + 1);

  bootState_t     state, nextState;
  logic [2:0]     modeQ;
  logic [WCW-1:0] waitCnt;
  logic           holdOff;
  logic           lastWait;

  assign lastWait = (state == S_READ) && (waitCnt == WCW'(WAIT_CYCLES - 1));

  always_comb begin
    nextState = state;
    case (state)
      S_START: begin
        if (modeQ == MODE_BYTE_BOOT)      nextState = S_READ;
        else if (modeQ == MODE_HOST_BOOT) nextState = S_HOST;
        else                              nextState = S_HALT;
      end
      S_READ:   if (lastWait) nextState = S_GAP;
      S_GAP:    nextState = (wordEnd && lastWord) ? S_FINISH : S_READ;
      S_HOST:   if (hostZeroWr) nextState = S_FINISH;
      S_FINISH: nextState = S_RUN;
      default:  nextState = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_START;
      modeQ   <= modePins;
      waitCnt <= '0;
      holdOff <= 1'b1;
    end else begin
      state <= nextState;
      if ((state == S_READ) && !lastWait) waitCnt <= waitCnt + WCW'(1);
      else                                waitCnt <= '0;
      if (nextState == S_FINISH) holdOff <= 1'b0;
    end
  end

  always_comb begin
    ctl.readStrobe = (state == S_READ);
    ctl.capture    = lastWait;
    ctl.stepByte   = (state == S_GAP);
    ctl.hostAccept = (state == S_HOST) || (state == S_FINISH) || (state == S_RUN);
  end

  assign coreRun  = !holdOff;
  assign bootDone = (state == S_FINISH);

endmodule

// File: rtl/boot_datapath.sv
module boot_datapath
  import boot_pkg::*;
#(
  parameter int PM_WIDTH   = 24,
  parameter int PM_DEPTH   = 256,
  parameter int EXT_AW     = 16,
  parameter int BOOT_WORDS = 32,
  parameter int PM_AW      = $clog2(PM_DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  bootCtl_t            ctl,
  input  logic [7:0]          byteData,
  input  logic                hostWr,
  input  logic [PM_AW-1:0]    hostAddr,
  input  logic [PM_WIDTH-1:0] hostData,
  input  logic [PM_AW-1:0]    coreRdAddr,
  output logic [PM_WIDTH-1:0] coreRdData,
  output logic [EXT_AW-1:0]   byteAddr,
  output logic                byteRd,
  output logic                wordEnd,
  output logic                lastWord,
  output logic                hostZeroWr
);

  localparam int BYTES = PM_WIDTH / 8;
  localparam int BIW   = (BYTES < 2) ? 1 : $clog2(BYTES);
  localparam int CNT_W = $clog2(BOOT_WORDS + 1);

  logic [EXT_AW-1:0]   extAddr;
  logic [PM_AW-1:0]    intAddr;
  logic [CNT_W-1:0]    wordCnt;
  logic [BIW-1:0]      byteIdx;
  logic [PM_WIDTH-1:0] assemble;
  logic [PM_WIDTH-1:0] mem [PM_DEPTH];

  assign wordEnd    = (byteIdx == BIW'(BYTES - 1));
  assign lastWord   = (wordCnt == CNT_W'(1));
  assign hostZeroWr = hostWr && (hostAddr == '0);
  assign byteAddr   = extAddr;
  assign byteRd     = ctl.readStrobe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extAddr  <= '0;
      intAddr  <= '0;
      wordCnt  <= CNT_W'(BOOT_WORDS);
      byteIdx  <= '0;
      assemble <= '0;
    end else begin
      if (ctl.capture) assemble <= {assemble[PM_WIDTH-9:0], byteData};
      if (ctl.stepByte) begin
        extAddr <= extAddr + EXT_AW'(1);
        if (wordEnd) begin
          byteIdx <= '0;
          intAddr <= intAddr + PM_AW'(1);
          wordCnt <= wordCnt - CNT_W'(1);
        end else begin
          byteIdx <= byteIdx + BIW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.stepByte && wordEnd)      mem[intAddr]  <= assemble;
    else if (ctl.hostAccept && hostWr) mem[hostAddr] <= hostData;
    coreRdData <= mem[coreRdAddr];
  end

endmodule

// File: rtl/boot_loader.sv
module boot_loader
  import boot_pkg::*;
#(
  parameter int PM_WIDTH    = 24,
  parameter int PM_DEPTH    = 256,
  parameter int EXT_AW      = 16,
  parameter int BOOT_WORDS  = 32,
  parameter int WAIT_CYCLES = 3,
  parameter int PM_AW       = $clog2(PM_DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          modePins,
  output logic [EXT_AW-1:0]   byteAddr,
  output logic                byteRd,
  input  logic [7:0]          byteData,
  input  logic                hostWr,
  input  logic [PM_AW-1:0]    hostAddr,
  input  logic [PM_WIDTH-1:0] hostData,
  input  logic [PM_AW-1:0]    coreRdAddr,
  output logic [PM_WIDTH-1:0] coreRdData,
  output logic                coreRun,
  output logic                bootDone
);

  bootCtl_t ctl;
  logic     wordEnd, lastWord, hostZeroWr;

  boot_control #(
    .WAIT_CYCLES(WAIT_CYCLES)
  ) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .modePins  (modePins),
    .wordEnd   (wordEnd),
    .lastWord  (lastWord),
    .hostZeroWr(hostZeroWr),
    .ctl       (ctl),
    .coreRun   (coreRun),
    .bootDone  (bootDone)
  );

  boot_datapath #(
    .PM_WIDTH  (PM_WIDTH),
    .PM_DEPTH  (PM_DEPTH),
    .EXT_AW    (EXT_AW),
    .BOOT_WORDS(BOOT_WORDS),
    .PM_AW     (PM_AW)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .byteData  (byteData),
    .hostWr    (hostWr),
    .hostAddr  (hostAddr),
    .hostData  (hostData),
    .coreRdAddr(coreRdAddr),
    .coreRdData(coreRdData),
    .byteAddr  (byteAddr),
    .byteRd    (byteRd),
    .wordEnd   (wordEnd),
    .lastWord  (lastWord),
    .hostZeroWr(hostZeroWr)
  );

endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk
  import boot_pkg::*;
#(
  parameter int EXT_AW      = 16,
  parameter int WAIT_CYCLES = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        modePins,
  input logic [EXT_AW-1:0] byteAddr,
  input logic              byteRd,
  input logic              coreRun,
  input logic              bootDone
);

  logic [2:0]  modeSeen;
  int unsigned hiCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeSeen <= modePins;
      hiCnt    <= 0;
    end else begin
      hiCnt <= byteRd ? hiCnt + 1 : 0;
    end
  end

  p_no_strobe_other_r1: assert property (@(posedge clk) disable iff (!rstN)
    (modeSeen != MODE_BYTE_BOOT) |-> !byteRd);

  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (byteRd && $past(byteRd)) |-> $stable(byteAddr));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(byteRd) |=> (byteAddr == $past(byteAddr) + EXT_AW'(1)));

  p_strobe_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    byteRd |-> (hiCnt < WAIT_CYCLES));

  p_strobe_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(byteRd) |-> (hiCnt == WAIT_CYCLES));

  p_strobe_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    byteRd |-> !coreRun);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |=> !bootDone);

  p_done_with_run_r6: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |-> coreRun);

  p_run_from_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreRun) |-> bootDone);

  p_run_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    coreRun |=> coreRun);

endmodule

bind boot_loader boot_loader_chk #(
  .EXT_AW     (EXT_AW),
  .WAIT_CYCLES(WAIT_CYCLES)
) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .modePins(modePins),
  .byteAddr(byteAddr),
  .byteRd  (byteRd),
  .coreRun (coreRun),
  .bootDone(bootDone)
);

// File: tb/test_boot_loader.sv
`timescale 1ns/1ps
module test_boot_loader;

  localparam int WAIT  = 3;
  localparam int WORDS = 32;
  localparam int NREAD = 3 * WORDS;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  modePins = 3'b000;
  logic [15:0] byteAddr;
  logic        byteRd;
  logic [7:0]  byteData;
  logic        hostWr = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [23:0] hostData = '0;
  logic [7:0]  coreRdAddr = '0;
  logic [23:0] coreRdData;
  logic        coreRun, bootDone;

  always #2 clk = ~clk;

  logic [7:0]  bmem [256];
  logic [23:0] expMem [256];
  bit          expValid [256];

  assign byteData = bmem[byteAddr[7:0]];

  boot_loader i_boot_loader (
    .clk(clk), .rstN(rstN), .modePins(modePins),
    .byteAddr(byteAddr), .byteRd(byteRd), .byteData(byteData),
    .hostWr(hostWr), .hostAddr(hostAddr), .hostData(hostData),
    .coreRdAddr(coreRdAddr), .coreRdData(coreRdData),
    .coreRun(coreRun), .bootDone(bootDone)
  );

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] wordOf(int k);
    return {bmem[3*k], bmem[3*k+1], bmem[3*k+2]};
  endfunction

  // Port monitor: strobe shape, addresses, completion pulse
  int expAddr, hiLen, loLen, strobeCnt;
  logic prevRd, prevDone, prevRun;
  always @(negedge clk) begin
    if (!rstN) begin
      expAddr = 0; hiLen = 0; loLen = 0; strobeCnt = 0;
      prevRd = 0; prevDone = 0; prevRun = 0;
    end else begin
      if (byteRd) begin
        if (!prevRd) begin
          check(byteAddr == expAddr[15:0], "R2 byte address", byteAddr, expAddr);
          if (strobeCnt > 0) check(loLen == 1, "R3 gap length", loLen, 1);
          expAddr++;
          strobeCnt++;
          hiLen = 0;
        end
        hiLen++;
      end else begin
        if (prevRd) begin
          check(hiLen == WAIT, "R3 strobe width", hiLen, WAIT);
          loLen = 0;
        end
        loLen++;
      end
      if (bootDone && prevDone) check(0, "R6 done longer than one cycle", 2, 1);
      if (bootDone) check(coreRun, "R6 run with done", coreRun, 1);
      if (coreRun && !prevRun) check(bootDone, "R6 run rises only with done", bootDone, 1);
      if (prevRun && !coreRun) check(0, "R6 run dropped", 0, 1);
      prevRd = byteRd; prevDone = bootDone; prevRun = coreRun;
    end
  end

  task automatic resetInto(logic [2:0] m);
    @(negedge clk);
    rstN = 1'b0;
    modePins = m;
    hostWr = 1'b0;
    repeat (4) @(negedge clk);
    check(!coreRun && !byteRd && !bootDone, "R6 reset state",
          {coreRun, byteRd, bootDone}, 0);
    rstN = 1'b1;
  endtask

  task automatic hostWrite(logic [7:0] a, logic [23:0] d);
    hostWr = 1'b1; hostAddr = a; hostData = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic readWord(logic [7:0] a, output logic [23:0] d);
    coreRdAddr = a;
    @(negedge clk);
    d = coreRdData;
  endtask

  task automatic haltRun(logic [2:0] m);
    logic [23:0] d;
    resetInto(m);
    @(negedge clk);
    hostWrite(8'd5, expMem[5] ^ 24'h5A5A5A);
    repeat (200) @(negedge clk);
    check(!coreRun, "R1 other mode keeps core held", coreRun, 0);
    check(strobeCnt == 0, "R1 other mode no strobes", strobeCnt, 0);
    readWord(8'd5, d);
    check(d == expMem[5], "R8 host write ignored in other mode", d, expMem[5]);
    readWord(8'd0, d);
    check(d == expMem[0], "R10 memory kept over reset", d, expMem[0]);
  endtask

  task automatic byteBoot(bit poke);
    int cycles;
    logic [23:0] d;
    for (int i = 0; i < 256; i++) bmem[i] = 8'($urandom);
    resetInto(3'b000);
    cycles = 0;
    while (cycles < 3000) begin
      @(negedge clk);
      cycles++;
      if (poke) hostWr = 1'b0;
      if (bootDone) break;
      check(!coreRun, "R6 held during byte boot", coreRun, 0);
      if (poke && cycles == 50) begin
        hostWr = 1'b1; hostAddr = 8'd40; hostData = ~expMem[40];
      end
    end
    hostWr = 1'b0;
    check(cycles == 1 + NREAD * (WAIT + 1), "R6 done cycle", cycles, 1 + NREAD * (WAIT + 1));
    repeat (20) @(negedge clk);
    check(strobeCnt == NREAD, "R4 read count", strobeCnt, NREAD);
    check(coreRun, "R6 run stays high", coreRun, 1);
    for (int k = 0; k < WORDS; k++) begin
      readWord(8'(k), d);
      check(d == wordOf(k), "R5 assembled word", d, wordOf(k));
      expMem[k] = wordOf(k);
      expValid[k] = 1'b1;
    end
    readWord(8'd32, d);
    check(d == expMem[32], "R5 word past boot untouched", d, expMem[32]);
    readWord(8'd40, d);
    check(d == expMem[40], "R8 host write ignored in byte boot", d, expMem[40]);
  endtask

  initial begin
    logic [23:0] d;
    logic [7:0]  a;
    logic [2:0]  m;
    void'($urandom(32'h1F2E));
    for (int i = 0; i < 256; i++) begin
      bmem[i] = '0; expMem[i] = '0; expValid[i] = 1'b0;
    end

    // Host boot
    resetInto(3'b101);
    repeat (3) @(negedge clk);
    hostWrite(8'd5, 24'h123456);  expMem[5]  = 24'h123456; expValid[5]  = 1;
    hostWrite(8'd32, 24'hABCDEF); expMem[32] = 24'hABCDEF; expValid[32] = 1;
    hostWrite(8'd40, 24'h0F0F0F); expMem[40] = 24'h0F0F0F; expValid[40] = 1;
    for (int i = 0; i < 20; i++) begin
      a = 8'(1 + ($urandom % 255));
      d = 24'($urandom);
      hostWrite(a, d);
      expMem[a] = d; expValid[a] = 1'b1;
    end
    check(!coreRun, "R7 core held before location 0", coreRun, 0);
    check(strobeCnt == 0, "R7 no byte reads in host boot", strobeCnt, 0);
    d = 24'($urandom);
    hostWr = 1'b1; hostAddr = 8'd0; hostData = d;
    @(negedge clk);
    check(bootDone && coreRun, "R7 release on location 0", {bootDone, coreRun}, 2'b11);
    hostWr = 1'b0;
    expMem[0] = d; expValid[0] = 1'b1;
    for (int i = 0; i < 256; i++) begin
      if (expValid[i]) begin
        readWord(8'(i), d);
        check(d == expMem[i], "R7 R9 host word readback", d, expMem[i]);
      end
    end

    // Modes selecting neither boot path
    haltRun(3'b001);
    haltRun(3'b011);
    haltRun(3'b111);

    // Byte-stream boots
    byteBoot(1'b1);
    byteBoot(1'b0);
    byteBoot(1'b0);

    // Random non-boot modes after byte boot
    for (int i = 0; i < 2; i++) begin
      m = 3'($urandom);
      if (m == 3'b000 || m == 3'b101) m = 3'b110;
      haltRun(m);
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule